// File: doc/BRIEF.md
# Broadcast Class and Scan Responder

This block decides whether a bus module takes part in a broadcast operation and drives the module's contribution to a shared wired status line (the T-pin) during polling scans. When an address phase opens, it examines the incoming broadcast code and sorts it into one of three kinds: a class broadcast, a buffer-empty poll or a sparse-data scan. A class broadcast selects the module only when the matching bit of a software-programmed class-enable mask is set. An ordinary, non-broadcast address phase selects the module when its geographic address matches.

During a scan, the first read cycle of the open address phase fixes the T-pin value from the event buffer state. An empty poll reports an empty circular buffer. A sparse-data scan reports that the event just loaded still holds unsuppressed words, which means its word count is not 1. The sparse answer has meaning only once a load-next-event command has been executed, so it stays low until the first such command after reset. Bus handshaking such as acknowledge and wait is handled outside this block.

Top module: `bc_responder`

## Requirements
- R1: After reset the class-enable mask reads back as 0, and `selected` and `tpin` are low.
- R2: A cycle with `reg_wr_en` high loads `reg_wr_data` into the mask, and `reg_rd_data` shows the new value from the next cycle on.
- R3: A class broadcast has code upper nibble 0x1, bits [3:2] zero and the class number in bits [1:0]. It sets `selected` one cycle after the address phase opens if, and only if, the mask bit for that class is set.
- R4: When `addr_valid` is low at a clock edge, `selected` and `tpin` are low after that edge.
- R5: A non-broadcast address phase sets `selected` one cycle after it opens exactly when `geo_hit` is high.
- R6: Code 0x20 is the empty poll. It selects the module regardless of the mask, and `tpin` goes high one cycle after the first `rd_strobe` when `buf_empty` is high in that read cycle.
- R7: Code 0x30 is the sparse-data scan. It selects the module, and `tpin` goes high one cycle after the first `rd_strobe` when `word_count` is not 1 in that read cycle.
- R8: Until the first `lne_pulse` after reset, a sparse-data scan leaves `tpin` low whatever the word count.
- R9: Once a scan's first read has set `tpin`, the value holds for the rest of the address phase. Later reads and changes to `buf_empty` do not alter it.
- R10: `tpin` never rises without a read in the cycle before, and class broadcasts never drive it.
- R11: Any other broadcast code, including a class code with nonzero bits [3:2], leaves `selected` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | Address phase active |
| bcast | input | 1 | Address phase is a broadcast |
| bcast_code | input | CODE_W | Broadcast code, sampled when the address phase opens |
| geo_hit | input | 1 | Geographic address match (register or data space) |
| rd_strobe | input | 1 | Read data cycle in progress |
| reg_wr_en | input | 1 | Write strobe for the class-enable mask |
| reg_wr_data | input | CLASS_N | Mask write data |
| reg_rd_data | output | CLASS_N | Mask read data |
| buf_empty | input | 1 | Circular event buffer is empty |
| word_count | input | WC_W | Word count of the currently loaded event |
| lne_pulse | input | 1 | Load-next-event command executed |
| selected | output | 1 | Module is selected for this address phase |
| tpin | output | 1 | Registered T-pin drive |

## Verification
On every cycle, the assertions check that the mask is clear after reset and follows each write, that the outputs drop once the address phase is removed, that a raised T-pin holds while the phase stays open, and that the T-pin rises only after a read. The bench's scenarios are the only way to show which codes select the module under which mask. They also show the empty and sparse answers, including the word count of exactly 1, and the suppression of the sparse answer before the first load-next-event. Rejection of malformed codes and geographic selection likewise depend on the bench.

// File: rtl/bc_pkg.sv
// Package: shared code kinds and function-nibble values for the
// broadcast responder. Assumes the function sits in the top nibble.
package bc_pkg;
    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_CLASS  = 2'd1,
        BC_EMPTY  = 2'd2,
        BC_SPARSE = 2'd3
    } bc_kind_e;

    localparam logic [3:0] FN_CLASS  = 4'h1;
    localparam logic [3:0] FN_EMPTY  = 4'h2;
    localparam logic [3:0] FN_SPARSE = 4'h3;
endpackage

// File: rtl/bc_decode.sv
// Module: bc_decode
// Purely combinational. Sorts a broadcast code into a kind and reports
// whether a class broadcast hits an enabled class. Assumes that
// CODE_W - 4 >= log2(CLASS_N), so the class field fits below the nibble.
module bc_decode
    import bc_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int CLASS_N = 4
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [CLASS_N-1:0] mask,
    output bc_kind_e           kind,
    output logic               class_hit
);
    localparam int CLS_W = (CLASS_N > 1) ? $clog2(CLASS_N) : 1;

    logic [3:0]         fn;
    logic [CODE_W-5:0]  low;
    logic [CLS_W-1:0]   cls;
    logic [CLASS_N-1:0] cls_match;

    assign fn  = code[CODE_W-1 -: 4];
    assign low = code[CODE_W-5:0];
    assign cls = code[CLS_W-1:0];

    // Per-class comparator against the enable mask
    for (genvar g = 0; g < CLASS_N; g++) begin : g_cls
        assign cls_match[g] = (cls == CLS_W'(g)) && mask[g];
    end

    assign class_hit = |cls_match;

    // Kind decode; reserved bits must be zero for a valid code
    always_comb begin
        kind = BC_NONE;
        if (fn == FN_CLASS && (low >> CLS_W) == '0)
            kind = BC_CLASS;
        else if (fn == FN_EMPTY && low == '0)
            kind = BC_EMPTY;
        else if (fn == FN_SPARSE && low == '0)
            kind = BC_SPARSE;
    end
endmodule

// File: rtl/bc_class_reg.sv
// Module: bc_class_reg
// Read/write class-enable mask. Resets to zero so class broadcasts are
// ignored until software configures it.
module bc_class_reg #(
    parameter int CLASS_N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CLASS_N-1:0] wr_data,
    output logic [CLASS_N-1:0] mask
);
    // Mask storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (wr_en)
            mask <= wr_data;
    end
endmodule

// File: rtl/bc_tpin_ctrl.sv
// Module: bc_tpin_ctrl
// Holds the selection and scan state for one address phase and drives
// the registered T-pin. Assumes the code is valid on the cycle the phase
// opens (addr_start) and that the read strobe comes later in the phase.
module bc_tpin_ctrl
    import bc_pkg::*;
#(
    parameter int WC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_valid,
    input  logic            addr_start,
    input  logic            bcast,
    input  logic            geo_hit,
    input  bc_kind_e        kind,
    input  logic            class_hit,
    input  logic            rd_strobe,
    input  logic            buf_empty,
    input  logic [WC_W-1:0] word_count,
    input  logic            lne_pulse,
    output logic            selected,
    output logic            tpin
);
    bc_kind_e scan_q;
    logic     answered_q;
    logic     lne_seen_q;
    logic     sel_next;
    logic     scan_cond;

    // Selection decision taken when the address phase opens
    always_comb begin
        if (!bcast)
            sel_next = geo_hit;
        else begin
            unique case (kind)
                BC_CLASS:            sel_next = class_hit;
                BC_EMPTY, BC_SPARSE: sel_next = 1'b1;
                default:             sel_next = 1'b0;
            endcase
        end
    end

    // Value the T-pin takes on the first read of a scan
    always_comb begin
        unique case (scan_q)
            BC_EMPTY:  scan_cond = buf_empty;
            BC_SPARSE: scan_cond = lne_seen_q && (word_count != WC_W'(1));
            default:   scan_cond = 1'b0;
        endcase
    end

    // Remembers whether any load-next-event has run since reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            lne_seen_q <= 1'b0;
        else if (lne_pulse)
            lne_seen_q <= 1'b1;
    end

    // Per-phase selection, scan kind and T-pin state
    always_ff @(posedge clk) begin
        if (!rst_n || !addr_valid) begin
            selected   <= 1'b0;
            scan_q     <= BC_NONE;
            answered_q <= 1'b0;
            tpin       <= 1'b0;
        end else if (addr_start) begin
            selected   <= sel_next;
            scan_q     <= (bcast && (kind == BC_EMPTY || kind == BC_SPARSE)) ? kind : BC_NONE;
            answered_q <= 1'b0;
            tpin       <= 1'b0;
        end else if (rd_strobe && !answered_q && scan_q != BC_NONE) begin
            answered_q <= 1'b1;
            tpin       <= scan_cond;
        end
    end
endmodule

// File: rtl/bc_responder.sv
// Module: bc_responder (top)
// Broadcast class and scan responder. Detects the opening of each address
// phase, decodes the broadcast code against the class mask and drives the
// selection flag and the T-pin. Assumes addr_valid drops between phases.
module bc_responder
    import bc_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int CLASS_N = 4,
    parameter int WC_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_valid,
    input  logic               bcast,
    input  logic [CODE_W-1:0]  bcast_code,
    input  logic               geo_hit,
    input  logic               rd_strobe,
    input  logic               reg_wr_en,
    input  logic [CLASS_N-1:0] reg_wr_data,
    output logic [CLASS_N-1:0] reg_rd_data,
    input  logic               buf_empty,
    input  logic [WC_W-1:0]    word_count,
    input  logic               lne_pulse,
    output logic               selected,
    output logic               tpin
);
    logic     addr_q;
    logic     addr_start;
    bc_kind_e kind;
    logic     class_hit;

    // Previous address-phase level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= 1'b0;
        else
            addr_q <= addr_valid;
    end

    assign addr_start = addr_valid && !addr_q;

    bc_class_reg #(.CLASS_N(CLASS_N)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .mask    (reg_rd_data)
    );

    bc_decode #(.CODE_W(CODE_W), .CLASS_N(CLASS_N)) u_dec (
        .code      (bcast_code),
        .mask      (reg_rd_data),
        .kind      (kind),
        .class_hit (class_hit)
    );

    bc_tpin_ctrl #(.WC_W(WC_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .addr_start (addr_start),
        .bcast      (bcast),
        .geo_hit    (geo_hit),
        .kind       (kind),
        .class_hit  (class_hit),
        .rd_strobe  (rd_strobe),
        .buf_empty  (buf_empty),
        .word_count (word_count),
        .lne_pulse  (lne_pulse),
        .selected   (selected),
        .tpin       (tpin)
    );
endmodule

// File: rtl/bc_responder_chk.sv
// Module: bc_responder_chk
// Port-level checker for bc_responder, attached by bind below.
module bc_responder_chk #(
    parameter int CODE_W  = 8,
    parameter int CLASS_N = 4,
    parameter int WC_W    = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               addr_valid,
    input logic               bcast,
    input logic [CODE_W-1:0]  bcast_code,
    input logic               geo_hit,
    input logic               rd_strobe,
    input logic               reg_wr_en,
    input logic [CLASS_N-1:0] reg_wr_data,
    input logic [CLASS_N-1:0] reg_rd_data,
    input logic               buf_empty,
    input logic [WC_W-1:0]    word_count,
    input logic               lne_pulse,
    input logic               selected,
    input logic               tpin
);
    p_mask_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_rd_data == '0 && !selected && !tpin));

    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data == $past(reg_wr_data)));

    p_phase_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> (!selected && !tpin));

    p_tpin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tpin && addr_valid) |=> tpin);

    p_tpin_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tpin) |-> $past(rd_strobe));
endmodule

bind bc_responder bc_responder_chk #(
    .CODE_W(CODE_W), .CLASS_N(CLASS_N), .WC_W(WC_W)
) u_chk (.*);

// File: tb/sim_bc_responder.sv
// Bench for bc_responder: vector table walk, then directed corner cases.
module sim_bc_responder;
    localparam int CODE_W  = 8;
    localparam int CLASS_N = 4;
    localparam int WC_W    = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               addr_valid = 1'b0, bcast = 1'b0, geo_hit = 1'b0;
    logic [CODE_W-1:0]  bcast_code = '0;
    logic               rd_strobe = 1'b0, reg_wr_en = 1'b0;
    logic [CLASS_N-1:0] reg_wr_data = '0;
    logic [CLASS_N-1:0] reg_rd_data;
    logic               buf_empty = 1'b0;
    logic [WC_W-1:0]    word_count = '0;
    logic               lne_pulse = 1'b0;
    logic               selected, tpin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bc_responder #(.CODE_W(CODE_W), .CLASS_N(CLASS_N), .WC_W(WC_W)) u0 (.*);

    // Vector: {mask[3:0], code[7:0], empty, wc[11:0], exp_sel, exp_tp}
    localparam int NV = 12;
    localparam logic [26:0] VEC [NV] = '{
        {4'b0001, 8'h10, 1'b1, 12'd1,  1'b1, 1'b0},
        {4'b0001, 8'h11, 1'b0, 12'd1,  1'b0, 1'b0},
        {4'b1010, 8'h13, 1'b0, 12'd1,  1'b1, 1'b0},
        {4'b1010, 8'h12, 1'b0, 12'd1,  1'b0, 1'b0},
        {4'b0000, 8'h20, 1'b1, 12'd1,  1'b1, 1'b1},
        {4'b0000, 8'h20, 1'b0, 12'd1,  1'b1, 1'b0},
        {4'b0000, 8'h30, 1'b0, 12'd1,  1'b1, 1'b0},
        {4'b0000, 8'h30, 1'b0, 12'd0,  1'b1, 1'b1},
        {4'b0000, 8'h30, 1'b1, 12'd65, 1'b1, 1'b1},
        {4'b1111, 8'h55, 1'b1, 12'd3,  1'b0, 1'b0},
        {4'b1111, 8'h1C, 1'b1, 12'd3,  1'b0, 1'b0},
        {4'b1111, 8'h21, 1'b1, 12'd3,  1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_mask(input logic [CLASS_N-1:0] m);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = m;
        tick();
        chk("R2 mask readback", 32'(reg_rd_data), 32'(m));
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Open a broadcast phase, do one read, close the phase
    task automatic bcast_seq(input string req, input logic [7:0] code,
                             input logic emp, input logic [WC_W-1:0] wc,
                             input logic exp_sel, input logic exp_tp);
        @(negedge clk);
        addr_valid = 1'b1; bcast = 1'b1; bcast_code = code;
        buf_empty = emp; word_count = wc;
        tick();
        chk({req, " selected"}, 32'(selected), 32'(exp_sel));
        chk("R10 tpin before read", 32'(tpin), 32'd0);
        @(negedge clk);
        rd_strobe = 1'b1;
        tick();
        chk({req, " tpin"}, 32'(tpin), 32'(exp_tp));
        @(negedge clk);
        rd_strobe = 1'b0; addr_valid = 1'b0; bcast = 1'b0;
        tick();
        chk("R4 selected dropped", 32'(selected), 32'd0);
        chk("R4 tpin dropped", 32'(tpin), 32'd0);
    endtask

    function automatic string tag_of(input logic [7:0] c);
        case (c)
            8'h10, 8'h11, 8'h12, 8'h13: return "R3";
            8'h20: return "R6";
            8'h30: return "R7";
            default: return "R11";
        endcase
    endfunction

    initial begin
        repeat (3) tick();
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 mask after reset", 32'(reg_rd_data), 32'd0);
        chk("R1 selected after reset", 32'(selected), 32'd0);
        chk("R1 tpin after reset", 32'(tpin), 32'd0);

        // R8: sparse scan before any load-next-event stays low
        bcast_seq("R8", 8'h30, 1'b0, 12'd7, 1'b1, 1'b0);

        @(negedge clk);
        lne_pulse = 1'b1;
        @(negedge clk);
        lne_pulse = 1'b0;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            write_mask(VEC[i][26:23]);
            bcast_seq(tag_of(VEC[i][22:15]), VEC[i][22:15], VEC[i][14],
                      VEC[i][13:2], VEC[i][1], VEC[i][0]);
        end

        // R5: geographic address selection
        @(negedge clk);
        addr_valid = 1'b1; bcast = 1'b0; geo_hit = 1'b1;
        tick();
        chk("R5 geo hit selects", 32'(selected), 32'd1);
        @(negedge clk);
        addr_valid = 1'b0; geo_hit = 1'b0;
        tick();
        @(negedge clk);
        addr_valid = 1'b1;
        tick();
        chk("R5 geo miss ignored", 32'(selected), 32'd0);
        @(negedge clk);
        addr_valid = 1'b0;
        tick();

        // R9: tpin holds through later reads and buffer changes
        @(negedge clk);
        addr_valid = 1'b1; bcast = 1'b1; bcast_code = 8'h20; buf_empty = 1'b1;
        tick();
        @(negedge clk);
        rd_strobe = 1'b1;
        tick();
        chk("R9 tpin set", 32'(tpin), 32'd1);
        @(negedge clk);
        rd_strobe = 1'b0; buf_empty = 1'b0;
        tick();
        @(negedge clk);
        rd_strobe = 1'b1;
        tick();
        tick();
        chk("R9 tpin held", 32'(tpin), 32'd1);
        @(negedge clk);
        rd_strobe = 1'b0; addr_valid = 1'b0; bcast = 1'b0;
        tick();
        chk("R4 tpin released", 32'(tpin), 32'd0);

        // R1: reset clears a programmed mask
        write_mask(4'b1111);
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 mask cleared by reset", 32'(reg_rd_data), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule